// File: doc/BRIEF.md
# Dual-Output PWM Generator Core

This block is one pulse-width channel built around a 16-bit counter. The counter either falls from a period value to zero and reloads, or climbs from zero to the period value and falls back again. Two compare values turn counter matches into events. In up/down mode each match is tagged with the direction of travel. Each event applies a 2-bit action to the two raw outputs, A and B. The same events, after masking, also give an interrupt pulse and a converter-start pulse.

Period and compare values written through the register port are first held in staging registers. The running copies take them only while the counter sits at zero. In immediate mode this happens at every zero. In synchronized mode it happens at the first zero after a shared update strobe, so several channels switch together. A shared clear input forces the count to zero, which keeps several channels with the same period in step.

Top module: `pwm_gen_core`

## Requirements
- R1: In falling mode (control bit 1 = 0) an enabled counter decrements by one per clock and reloads the period value after zero, so zero repeats every period+1 cycles. `zero_pulse` is high for the one cycle the count is 0, and `load_pulse` is high in the cycle right after it.
- R2: In up/down mode (control bit 1 = 1) the counter runs 0 up to the period and back to 0. The period value is reached `period` cycles after zero, and the next zero comes another `period` cycles later. `dir_up` is high while climbing, including at the peak, and low while falling. In falling mode `dir_up` is always low.
- R3: A compare match gives an up-match event when `dir_up` is high and a down-match event when it is low. Event bits: 0 zero, 1 period, 2 A up-match, 3 A down-match, 4 B up-match, 5 B down-match.
- R4: A compare value larger than the active period value never gives a match event.
- R5: A match in the same cycle as a zero or period event is dropped. Output A reacts only to A matches, and output B only to B matches.
- R6: Each output has an 8-bit action word: bits [1:0] zero, [3:2] period, [5:4] up-match, [7:6] down-match. The codes are 00 keep, 01 toggle, 10 force low, 11 force high. The zero action is applied before the period action. The output shows the result one clock after the event.
- R7: In immediate mode (control bit 2 = 0) new period and compare values take effect when the counter next sits at zero. The period already running finishes on the old value.
- R8: In synchronized mode (control bit 2 = 1) written values stay staged until `upd_strobe`. They are then applied at the next zero.
- R9: `cnt_clear` makes the count 0 on the next clock.
- R10: The interrupt mask is bits [5:0] and the converter mask is bits [13:8] of register 6, using the R3 bit order. `irq_pulse` and `adc_pulse` are high in the same cycle as any selected event.
- R11: With control bit 0 low, the count is 0, no events fire, and both outputs go low one clock later. Setting the bit makes the very next cycle a zero event.
- R12: Write addresses: 0 control, 1 period, 2 compare A, 3 compare B, 4 action A, 5 action B, 6 masks. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write value |
| upd_strobe | input | 1 | Shared synchronized-update strobe |
| cnt_clear | input | 1 | Shared counter clear |
| pwm_a | output | 1 | Raw output A |
| pwm_b | output | 1 | Raw output B |
| dir_up | output | 1 | Counting direction, high while climbing |
| zero_pulse | output | 1 | Count-is-zero event |
| load_pulse | output | 1 | Count-equals-period event |
| irq_pulse | output | 1 | Masked event pulse for interrupts |
| adc_pulse | output | 1 | Masked event pulse for converter start |

## Verification
Several properties are checked on every cycle: the count never goes above the active period, falling mode keeps the direction low, a zero in falling mode is followed by a period event, a clear zeroes the count, an oversized compare stays silent, and a disabled channel drives both outputs low. Other behaviour can only be shown by the directed scenarios: exact period lengths, action ordering and coincidence dropping, mask routing, and whether a new value lands at the right zero in each update mode.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

    localparam int EV_NUM       = 6;
    localparam int EV_ZERO      = 0;
    localparam int EV_LOAD      = 1;
    localparam int EV_AUP       = 2;
    localparam int EV_ADN       = 3;
    localparam int OUT_NUM      = 2;
    localparam int ACT_W        = 8;
    localparam int MASK_ADC_LSB = 8;

    localparam int REG_CTRL = 0;
    localparam int REG_LOAD = 1;
    localparam int REG_CMPA = 2;
    localparam int REG_CMPB = 3;
    localparam int REG_ACTA = 4;
    localparam int REG_ACTB = 5;
    localparam int REG_MASK = 6;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_FLIP = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;

    function automatic logic act_apply(input logic [1:0] code, input logic cur);
        case (act_e'(code))
            ACT_FLIP: return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_gen_regs.sv
module pwm_gen_regs
    import pwm_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              upd_strobe,
    input  logic              at_zero,
    output logic              en,
    output logic              mode_ud,
    output logic [CNT_W-1:0]  load_act,
    output logic [CNT_W-1:0]  load_next,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic [ACT_W-1:0]  act_a,
    output logic [ACT_W-1:0]  act_b,
    output logic [EV_NUM-1:0] irq_mask,
    output logic [EV_NUM-1:0] adc_mask
);

    typedef struct packed {
        logic              en;
        logic              ud;
        logic              sync;
        logic              armed;
        logic [CNT_W-1:0]  sh_load;
        logic [CNT_W-1:0]  sh_a;
        logic [CNT_W-1:0]  sh_b;
        logic [CNT_W-1:0]  ac_load;
        logic [CNT_W-1:0]  ac_a;
        logic [CNT_W-1:0]  ac_b;
        logic [ACT_W-1:0]  act_a;
        logic [ACT_W-1:0]  act_b;
        logic [EV_NUM-1:0] irq_m;
        logic [EV_NUM-1:0] adc_m;
    } regs_t;

    regs_t s_d, s_q;
    logic  apply;

    // staged values move to the running copy only at a zero count
    assign apply = at_zero && (!s_q.sync || s_q.armed);

    always_comb begin
        s_d = s_q;
        if (apply) begin
            s_d.ac_load = s_q.sh_load;
            s_d.ac_a    = s_q.sh_a;
            s_d.ac_b    = s_q.sh_b;
            s_d.armed   = 1'b0;
        end
        if (upd_strobe) begin
            s_d.armed = 1'b1;
        end
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(REG_CTRL): begin
                    s_d.en   = wr_data[0];
                    s_d.ud   = wr_data[1];
                    s_d.sync = wr_data[2];
                end
                ADDR_W'(REG_LOAD): s_d.sh_load = wr_data;
                ADDR_W'(REG_CMPA): s_d.sh_a    = wr_data;
                ADDR_W'(REG_CMPB): s_d.sh_b    = wr_data;
                ADDR_W'(REG_ACTA): s_d.act_a   = wr_data[ACT_W-1:0];
                ADDR_W'(REG_ACTB): s_d.act_b   = wr_data[ACT_W-1:0];
                ADDR_W'(REG_MASK): begin
                    s_d.irq_m = wr_data[EV_NUM-1:0];
                    s_d.adc_m = wr_data[MASK_ADC_LSB +: EV_NUM];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en        = s_q.en;
    assign mode_ud   = s_q.ud;
    assign load_act  = s_q.ac_load;
    assign load_next = apply ? s_q.sh_load : s_q.ac_load;
    assign cmp_a     = s_q.ac_a;
    assign cmp_b     = s_q.ac_b;
    assign act_a     = s_q.act_a;
    assign act_b     = s_q.act_b;
    assign irq_mask  = s_q.irq_m;
    assign adc_mask  = s_q.adc_m;

endmodule

// File: rtl/pwm_gen_counter.sv
module pwm_gen_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_ud,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_act,
    input  logic [CNT_W-1:0] load_next,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             at_zero
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en || clear) begin
            s_d.cnt = '0;
            s_d.dir = 1'b0;
        end else if (!mode_ud) begin
            s_d.dir = 1'b0;
            s_d.cnt = (s_q.cnt == '0) ? load_next : s_q.cnt - 1'b1;
        end else if (s_q.cnt == '0) begin
            if (load_next == '0) begin
                s_d.cnt = '0;
                s_d.dir = 1'b0;
            end else begin
                s_d.cnt = CNT_W'(1);
                s_d.dir = 1'b1;
            end
        end else if (s_q.dir && s_q.cnt >= load_act) begin
            s_d.dir = 1'b0;
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (s_q.dir) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt     = s_q.cnt;
    assign dir_up  = s_q.dir;
    assign at_zero = (s_q.cnt == '0);

endmodule

// File: rtl/pwm_gen_out.sv
module pwm_gen_out
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ev_zero,
    input  logic             ev_load,
    input  logic             ev_up,
    input  logic             ev_dn,
    input  logic [ACT_W-1:0] act,
    output logic             pwm
);

    logic pwm_d, pwm_q;

    // zero first, then period, then the direction-tagged match
    always_comb begin
        pwm_d = pwm_q;
        if (ev_zero) pwm_d = act_apply(act[1:0], pwm_d);
        if (ev_load) pwm_d = act_apply(act[3:2], pwm_d);
        if (ev_up)   pwm_d = act_apply(act[5:4], pwm_d);
        if (ev_dn)   pwm_d = act_apply(act[7:6], pwm_d);
        if (!en)     pwm_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm = pwm_q;

endmodule

// File: rtl/pwm_gen_core.sv
module pwm_gen_core
    import pwm_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              upd_strobe,
    input  logic              cnt_clear,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              dir_up,
    output logic              zero_pulse,
    output logic              load_pulse,
    output logic              irq_pulse,
    output logic              adc_pulse
);

    logic              en_w, ud_w, dir_w, zero_w;
    logic [CNT_W-1:0]  load_act_w, load_next_w, cnt_w;
    logic [CNT_W-1:0]  cmp_w [OUT_NUM];
    logic [ACT_W-1:0]  act_w [OUT_NUM];
    logic [EV_NUM-1:0] irq_m_w, adc_m_w, ev_w;
    logic [OUT_NUM-1:0] pwm_w;
    logic              edge_ev;

    pwm_gen_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .upd_strobe(upd_strobe), .at_zero(zero_w),
        .en(en_w), .mode_ud(ud_w),
        .load_act(load_act_w), .load_next(load_next_w),
        .cmp_a(cmp_w[0]), .cmp_b(cmp_w[1]),
        .act_a(act_w[0]), .act_b(act_w[1]),
        .irq_mask(irq_m_w), .adc_mask(adc_m_w)
    );

    pwm_gen_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .en(en_w), .mode_ud(ud_w), .clear(cnt_clear),
        .load_act(load_act_w), .load_next(load_next_w),
        .cnt(cnt_w), .dir_up(dir_w), .at_zero(zero_w)
    );

    assign ev_w[EV_ZERO] = en_w && zero_w;
    assign ev_w[EV_LOAD] = en_w && (cnt_w == load_act_w);
    assign edge_ev       = ev_w[EV_ZERO] || ev_w[EV_LOAD];

    for (genvar g = 0; g < OUT_NUM; g++) begin : g_out
        logic hit;
        assign hit = en_w && (cnt_w == cmp_w[g]) && !edge_ev;
        assign ev_w[EV_AUP + 2*g] = hit && dir_w;
        assign ev_w[EV_ADN + 2*g] = hit && !dir_w;

        pwm_gen_out u_out (
            .clk(clk), .rst_n(rst_n), .en(en_w),
            .ev_zero(ev_w[EV_ZERO]), .ev_load(ev_w[EV_LOAD]),
            .ev_up(ev_w[EV_AUP + 2*g]), .ev_dn(ev_w[EV_ADN + 2*g]),
            .act(act_w[g]), .pwm(pwm_w[g])
        );
    end

    assign pwm_a      = pwm_w[0];
    assign pwm_b      = pwm_w[1];
    assign dir_up     = dir_w;
    assign zero_pulse = ev_w[EV_ZERO];
    assign load_pulse = ev_w[EV_LOAD];
    assign irq_pulse  = |(ev_w & irq_m_w);
    assign adc_pulse  = |(ev_w & adc_m_w);

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             mode_ud,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_act,
    input logic [CNT_W-1:0] cmp_a,
    input logic             a_up,
    input logic             a_dn,
    input logic             dir_up,
    input logic             zero_pulse,
    input logic             load_pulse,
    input logic             pwm_a,
    input logic             pwm_b
);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt <= load_act);

    p_reload_after_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode_ud && zero_pulse && !cnt_clear) |=> (load_pulse || !en || mode_ud));

    p_dir_low_falling_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !mode_ud) |=> !dir_up);

    p_big_cmp_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a > load_act) |-> (!a_up && !a_dn));

    p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> cnt == '0);

    p_off_outputs_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_a && !pwm_b));

endmodule

bind pwm_gen_core pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .mode_ud(ud_w),
    .cnt_clear(cnt_clear), .cnt(cnt_w), .load_act(load_act_w),
    .cmp_a(cmp_w[0]), .a_up(ev_w[EV_AUP]), .a_dn(ev_w[EV_ADN]),
    .dir_up(dir_w), .zero_pulse(zero_pulse), .load_pulse(load_pulse),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/tb_pwm_gen_core.sv
module tb_pwm_gen_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        upd_strobe;
    logic        cnt_clear;
    logic        pwm_a, pwm_b, dir_up, zero_pulse, load_pulse, irq_pulse, adc_pulse;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pwm_gen_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_strobe(upd_strobe), .cnt_clear(cnt_clear),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .dir_up(dir_up),
        .zero_pulse(zero_pulse), .load_pulse(load_pulse),
        .irq_pulse(irq_pulse), .adc_pulse(adc_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // called at a falling edge; returns at the falling edge after the write lands
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_zero(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!zero_pulse && n < 200);
    endtask

    task automatic wait_load(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!load_pulse && n < 200);
    endtask

    task automatic t_reset();
        chk("R12 reset pwm_a", pwm_a, 0);
        chk("R12 reset pwm_b", pwm_b, 0);
        chk("R11 reset zero_pulse", zero_pulse, 0);
        chk("R11 reset dir_up", dir_up, 0);
        chk("R10 reset irq", irq_pulse, 0);
        chk("R10 reset adc", adc_pulse, 0);
    endtask

    task automatic t_falling();
        int n;
        wr(0, 0); wr(1, 4); wr(6, 16'h0001);
        wr(0, 1);
        chk("R11 zero right after enable", zero_pulse, 1);
        chk("R10 irq on zero", irq_pulse, 1);
        step();
        chk("R1 period event after zero", load_pulse, 1);
        chk("R2 dir low in falling mode", dir_up, 0);
        chk("R10 irq quiet off-mask", irq_pulse, 0);
        wait_zero(n);
        chk("R1 period event to zero", n, 4);
        wait_zero(n);
        chk("R1 zero to zero", n, 5);
    endtask

    task automatic t_updown();
        int n;
        wr(0, 0); wr(1, 3); wr(6, 0);
        wr(0, 3);
        chk("R2 zero at start", zero_pulse, 1);
        step();
        chk("R2 dir high climbing", dir_up, 1);
        wait_load(n);
        chk("R2 climb length", n, 2);
        chk("R2 dir high at peak", dir_up, 1);
        step();
        chk("R2 dir low falling", dir_up, 0);
        wait_zero(n);
        chk("R2 fall length", n, 2);
        wait_load(n);
        chk("R2 zero to peak", n, 3);
    endtask

    task automatic t_actions();
        wr(0, 0); wr(1, 7); wr(2, 3); wr(3, 5);
        wr(4, 16'h0083); wr(5, 16'h00C2); wr(6, 16'h2008);
        wr(0, 1);
        step();
        chk("R6 zero drives A high", pwm_a, 1);
        chk("R6 zero drives B low", pwm_b, 0);
        step(); step();
        chk("R10 adc on B down-match", adc_pulse, 1);
        chk("R6 B before its action", pwm_b, 0);
        step();
        chk("R6 B down-match drives high", pwm_b, 1);
        chk("R10 irq quiet on B match", irq_pulse, 0);
        step();
        chk("R10 irq on A down-match", irq_pulse, 1);
        chk("R3 A still high", pwm_a, 1);
        step();
        chk("R3 A down-match drives low", pwm_a, 0);
    endtask

    task automatic t_updown_match();
        wr(0, 0); wr(1, 6); wr(2, 2); wr(4, 16'h00B0); wr(6, 16'h0804);
        wr(0, 3);
        step(); step();
        chk("R3 up-match irq", irq_pulse, 1);
        chk("R3 no down-match climbing", adc_pulse, 0);
        chk("R3 A low before up action", pwm_a, 0);
        step();
        chk("R3 up-match drives A high", pwm_a, 1);
        repeat (7) step();
        chk("R3 down-match adc", adc_pulse, 1);
        chk("R3 no up-match falling", irq_pulse, 0);
        chk("R3 A high before down action", pwm_a, 1);
        step();
        chk("R3 down-match drives A low", pwm_a, 0);
    endtask

    task automatic t_priority();
        wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
        wr(4, 16'h000D); wr(5, 16'h000B); wr(6, 0);
        wr(0, 1);
        step();
        chk("R6 period action after zero on A", pwm_a, 1);
        chk("R6 period action after zero on B", pwm_b, 0);
        step(); step();
        chk("R6 A stays high", pwm_a, 1);
        chk("R6 B stays low", pwm_b, 0);
    endtask

    task automatic t_coincide();
        int a_seen = 0;
        int i_seen = 0;
        int flips = 0;
        logic b_prev;
        wr(0, 0); wr(1, 7); wr(2, 7); wr(3, 2);
        wr(4, 16'h0040); wr(5, 16'h0040); wr(6, 16'h0008);
        wr(0, 1);
        b_prev = pwm_b;
        for (int k = 0; k < 16; k++) begin
            step();
            if (pwm_a) a_seen++;
            if (irq_pulse) i_seen++;
            if (pwm_b !== b_prev) flips++;
            b_prev = pwm_b;
        end
        chk("R5 match on period ignored for A", a_seen, 0);
        chk("R5 no A down-match irq", i_seen, 0);
        chk("R5 B toggles on its own matches", flips, 2);
    endtask

    task automatic t_big_cmp();
        int a_seen = 0;
        int i_seen = 0;
        wr(0, 0); wr(1, 7); wr(2, 9); wr(4, 16'h0050); wr(6, 16'h000C);
        wr(0, 1);
        for (int k = 0; k < 20; k++) begin
            step();
            if (pwm_a) a_seen++;
            if (irq_pulse) i_seen++;
        end
        chk("R4 oversized compare no toggle", a_seen, 0);
        chk("R4 oversized compare no event", i_seen, 0);
    endtask

    task automatic t_immediate();
        int n;
        wr(0, 0); wr(1, 4); wr(6, 0);
        wr(0, 1);
        wr(1, 2);
        wait_zero(n);
        chk("R7 running period keeps old value", n, 4);
        wait_zero(n);
        chk("R7 new period after zero", n, 3);
    endtask

    task automatic t_sync();
        int n;
        wr(0, 5);
        wr(1, 5);
        wait_zero(n);
        wait_zero(n);
        chk("R8 staged value held", n, 3);
        upd_strobe = 1'b1;
        step();
        upd_strobe = 1'b0;
        wait_zero(n);
        chk("R8 old value until zero", n, 2);
        wait_zero(n);
        chk("R8 new period after strobe", n, 6);
    endtask

    task automatic t_clear();
        int n;
        wait_zero(n);
        step(); step();
        cnt_clear = 1'b1;
        step();
        cnt_clear = 1'b0;
        chk("R9 clear gives zero", zero_pulse, 1);
        step();
        chk("R9 reload after clear", load_pulse, 1);
        wait_zero(n);
        chk("R9 period after clear", n, 5);
    endtask

    task automatic t_enable();
        int n;
        int z_seen = 0;
        wr(4, 16'h0003);
        wait_zero(n);
        step();
        chk("R6 zero drives A high before disable", pwm_a, 1);
        wr(0, 0);
        chk("R11 no zero when off", zero_pulse, 0);
        step();
        chk("R11 A low when off", pwm_a, 0);
        chk("R11 B low when off", pwm_b, 0);
        for (int k = 0; k < 5; k++) begin
            step();
            if (zero_pulse || load_pulse) z_seen++;
        end
        chk("R11 no events when off", z_seen, 0);
        wr(0, 1);
        chk("R11 enable starts at zero", zero_pulse, 1);
        step();
        chk("R11 reload after enable", load_pulse, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        upd_strobe = 1'b0;
        cnt_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_falling();
        t_updown();
        t_actions();
        t_updown_match();
        t_priority();
        t_coincide();
        t_big_cmp();
        t_immediate();
        t_sync();
        t_clear();
        t_enable();
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

endmodule